// File: doc/BRIEF.md
# Fault-Injection Trial Sequencer

This controller runs a single fault-injection trial on a target that holds two processors in lockstep. A host hands it one command, which carries a reset length and an injection delay. The sequencer then holds the target in reset and waits for the target to report that its workload is running. It sends a one-cycle synchronization pulse and turns on the enable for the periodic program-counter comparison ticks. After the requested delay it fires one injection strobe, which reaches the interrupt input of both processors in the same cycle.

From that strobe onward a saturating counter measures the detection latency in target clock cycles. The trial ends when the target reports a mismatch, or when the counter reaches its ceiling without a report. The host then sees a done flag, a status bit and the captured latency, and the sequencer is back in idle, ready for the next command. The default counter width of 24 bits covers latencies from about a thousand cycles up to well past a hundred thousand cycles.

Top module: `fi_trial_seq`

## Requirements
- R1: `cmd_ready` is high only while the sequencer is idle, and a trial starts on a cycle where `cmd_valid` and `cmd_ready` are both high. A `cmd_valid` raised while a trial runs is ignored: `cmd_ready` stays low and the running trial continues unchanged.
- R2: `tgt_reset` rises in the cycle after the command is accepted. It stays high for exactly max(`cmd_reset_len`, MIN_RST) cycles, with MIN_RST = 16 by default.
- R3: After reset, `tgt_sync` stays low until `tgt_workload_started` is seen high. `tgt_sync` is then a one-cycle pulse in the cycle after that sample.
- R4: `tgt_tick_en` is low during reset, during the wait for the workload and during the sync pulse. It is high from the cycle after the sync pulse until the trial ends, and low again in idle.
- R5: `tgt_inject` is a one-cycle pulse. Exactly D cycles separate the sync pulse from the injection pulse, where D is `cmd_inject_delay` (D = 0 puts the injection in the cycle right after sync).
- R6: If `tgt_error_det` is sampled high in the k-th cycle after the injection cycle, the trial ends with `res_status` = 0 (detected) and `res_latency` = k. The error input is ignored during the injection cycle itself.
- R7: If no error is seen through cycle 2^LAT_W−1 after injection, the latency counter saturates instead of wrapping. The trial ends with `res_status` = 1 (timeout) and `res_latency` all ones.
- R8: `res_done` rises on the same clock edge that returns the sequencer to idle. It stays high together with stable `res_status`/`res_latency` until the next accepted command, which clears it.
- R9: After `rst_n` is released, `cmd_ready` is high and `tgt_reset`, `tgt_sync`, `tgt_tick_en`, `tgt_inject` and `res_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a trial command |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_reset_len | input | RST_W | Requested target reset length in cycles |
| cmd_inject_delay | input | DLY_W | Cycles between sync pulse and injection |
| tgt_reset | output | 1 | Reset to both target processors |
| tgt_workload_started | input | 1 | Target reports that its workload has begun |
| tgt_sync | output | 1 | One-cycle synchronization pulse |
| tgt_tick_en | output | 1 | Enable for the comparison-tick generator |
| tgt_inject | output | 1 | Injection strobe to both processors' interrupt input |
| tgt_error_det | input | 1 | Target reports a program-counter mismatch |
| res_done | output | 1 | Trial finished, results valid |
| res_status | output | 1 | 0 = detected, 1 = timeout |
| res_latency | output | LAT_W | Cycles from injection to detection |

## Verification
The bench builds the sequencer with LAT_W = 8, so the latency ceiling is 255 cycles. With that width, both a detection in the very last counting cycle and a real timeout run in a few hundred cycles. RST_W = 6 lets a requested reset length fall both below and above the 16-cycle floor. DLY_W = 10 allows a zero delay next to a delay of a hundred cycles. A command poked in mid-trial and an error pulse placed on the injection cycle show that both are ignored.

// File: rtl/fi_seq_pkg.sv
package fi_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_RESET   = 3'd1,
      SQ_WAITRUN = 3'd2,
      SQ_SYNC    = 3'd3,
      SQ_ARM     = 3'd4,
      SQ_INJECT  = 3'd5,
      SQ_MEASURE = 3'd6
   } seq_state_t;

   typedef enum logic {
      ST_DETECTED = 1'b0,
      ST_TIMEOUT  = 1'b1
   } trial_status_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fi_down_timer.sv
module fi_down_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/fi_sat_counter.sv
module fi_sat_counter #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic         at_max
);

   logic [W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
      end else if (start) begin
         val_q <= W'(1);
      end else if (inc && !at_max) begin
         val_q <= val_q + 1'b1;
      end
   end

   assign value  = val_q;
   assign at_max = &val_q;

endmodule

// File: rtl/fi_seq_ctrl.sv
module fi_seq_ctrl
   import fi_seq_pkg::*;
#(
   parameter int unsigned RST_W = 8,
   parameter int unsigned DLY_W = 24,
   parameter int unsigned LAT_W = 24,
   localparam int unsigned TW   = max_u(RST_W, DLY_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [RST_W-1:0] rlen_eff,
   input  logic [DLY_W-1:0] cmd_delay,
   input  logic             run_seen,
   input  logic             err_seen,
   input  logic             tmr_zero,
   input  logic [LAT_W-1:0] lat_val,
   input  logic             lat_max,
   output seq_state_t       state,
   output logic             tmr_load,
   output logic [TW-1:0]    tmr_val,
   output logic             tmr_dec,
   output logic             lat_start,
   output logic             lat_inc,
   output logic             res_done,
   output logic             res_status,
   output logic [LAT_W-1:0] res_latency
);

   seq_state_t       state_q, state_d;
   logic [DLY_W-1:0] delay_q;
   logic             accept;
   logic             finish;
   trial_status_t    fin_status;

   assign accept = (state_q == SQ_IDLE) && cmd_valid;

   always_comb begin
      state_d    = state_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      tmr_dec    = 1'b0;
      lat_start  = 1'b0;
      lat_inc    = 1'b0;
      finish     = 1'b0;
      fin_status = ST_DETECTED;
      case (state_q)
         SQ_IDLE: begin
            if (cmd_valid) begin
               tmr_load = 1'b1;
               tmr_val  = TW'(rlen_eff) - TW'(1);
               state_d  = SQ_RESET;
            end
         end
         SQ_RESET: begin
            if (tmr_zero) state_d = SQ_WAITRUN;
            else          tmr_dec = 1'b1;
         end
         SQ_WAITRUN: begin
            if (run_seen) state_d = SQ_SYNC;
         end
         SQ_SYNC: begin
            if (delay_q == '0) begin
               state_d = SQ_INJECT;
            end else begin
               tmr_load = 1'b1;
               tmr_val  = TW'(delay_q) - TW'(1);
               state_d  = SQ_ARM;
            end
         end
         SQ_ARM: begin
            if (tmr_zero) state_d = SQ_INJECT;
            else          tmr_dec = 1'b1;
         end
         SQ_INJECT: begin
            lat_start = 1'b1;
            state_d   = SQ_MEASURE;
         end
         SQ_MEASURE: begin
            if (err_seen) begin
               finish  = 1'b1;
               state_d = SQ_IDLE;
            end else if (lat_max) begin
               finish     = 1'b1;
               fin_status = ST_TIMEOUT;
               state_d    = SQ_IDLE;
            end else begin
               lat_inc = 1'b1;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         delay_q     <= '0;
         res_done    <= 1'b0;
         res_status  <= 1'b0;
         res_latency <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            delay_q  <= cmd_delay;
            res_done <= 1'b0;
         end
         if (finish) begin
            res_done    <= 1'b1;
            res_status  <= fin_status;
            res_latency <= lat_val;
         end
      end
   end

   assign state = state_q;

endmodule

// File: rtl/fi_trial_seq.sv
module fi_trial_seq
   import fi_seq_pkg::*;
#(
   parameter int unsigned RST_W   = 8,
   parameter int unsigned DLY_W   = 24,
   parameter int unsigned LAT_W   = 24,
   parameter int unsigned MIN_RST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [RST_W-1:0] cmd_reset_len,
   input  logic [DLY_W-1:0] cmd_inject_delay,
   output logic             tgt_reset,
   input  logic             tgt_workload_started,
   output logic             tgt_sync,
   output logic             tgt_tick_en,
   output logic             tgt_inject,
   input  logic             tgt_error_det,
   output logic             res_done,
   output logic             res_status,
   output logic [LAT_W-1:0] res_latency
);

   localparam int unsigned TW = max_u(RST_W, DLY_W);

   initial begin
      assert (LAT_W >= 2) else $error("LAT_W must be at least 2");
      assert (RST_W >= 1 && DLY_W >= 1) else $error("field widths must be nonzero");
      assert (MIN_RST < (1 << RST_W)) else $error("MIN_RST does not fit RST_W");
   end

   logic [RST_W-1:0] rlen_eff;
   seq_state_t       state;
   logic             tmr_load, tmr_dec, tmr_zero;
   logic [TW-1:0]    tmr_val;
   logic             lat_start, lat_inc, lat_max;
   logic [LAT_W-1:0] lat_val;

   generate
      if (MIN_RST > 1) begin : g_floor
         assign rlen_eff = (cmd_reset_len < RST_W'(MIN_RST)) ? RST_W'(MIN_RST) : cmd_reset_len;
      end else begin : g_nozero
         assign rlen_eff = (cmd_reset_len == '0) ? RST_W'(1) : cmd_reset_len;
      end
   endgenerate

   fi_seq_ctrl #(
      .RST_W (RST_W),
      .DLY_W (DLY_W),
      .LAT_W (LAT_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .rlen_eff    (rlen_eff),
      .cmd_delay   (cmd_inject_delay),
      .run_seen    (tgt_workload_started),
      .err_seen    (tgt_error_det),
      .tmr_zero    (tmr_zero),
      .lat_val     (lat_val),
      .lat_max     (lat_max),
      .state       (state),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .tmr_dec     (tmr_dec),
      .lat_start   (lat_start),
      .lat_inc     (lat_inc),
      .res_done    (res_done),
      .res_status  (res_status),
      .res_latency (res_latency)
   );

   fi_down_timer #(.W(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .is_zero  (tmr_zero)
   );

   fi_sat_counter #(.W(LAT_W)) i_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (lat_start),
      .inc    (lat_inc),
      .value  (lat_val),
      .at_max (lat_max)
   );

   assign cmd_ready   = (state == SQ_IDLE);
   assign tgt_reset   = (state == SQ_RESET);
   assign tgt_sync    = (state == SQ_SYNC);
   assign tgt_inject  = (state == SQ_INJECT);
   assign tgt_tick_en = (state == SQ_ARM) || (state == SQ_INJECT) || (state == SQ_MEASURE);

endmodule

// File: rtl/fi_trial_seq_chk.sv
module fi_trial_seq_chk #(
   parameter int unsigned LAT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic             tgt_reset,
   input logic             tgt_workload_started,
   input logic             tgt_sync,
   input logic             tgt_tick_en,
   input logic             tgt_inject,
   input logic             res_done,
   input logic             res_status,
   input logic [LAT_W-1:0] res_latency
);

   assert_reset_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_reset) |-> $past(cmd_valid && cmd_ready));

   assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_reset || tgt_sync || tgt_tick_en) |-> !cmd_ready);

   assert_sync_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sync |-> $past(tgt_workload_started));

   assert_sync_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sync |=> !tgt_sync);

   assert_quiet_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_reset |-> (!tgt_tick_en && !tgt_sync && !tgt_inject));

   assert_inject_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_inject |=> !tgt_inject);

   assert_inject_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_inject |-> tgt_tick_en);

   assert_latency_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_done) |-> (res_latency != '0));

   assert_timeout_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(res_done) && res_status) |-> (&res_latency));

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_done) |-> (cmd_ready && !tgt_tick_en));

   assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && $past(res_done)) |-> ($stable(res_latency) && $stable(res_status)));

endmodule

bind fi_trial_seq fi_trial_seq_chk #(.LAT_W(LAT_W)) i_chk (
   .clk                  (clk),
   .rst_n                (rst_n),
   .cmd_valid            (cmd_valid),
   .cmd_ready            (cmd_ready),
   .tgt_reset            (tgt_reset),
   .tgt_workload_started (tgt_workload_started),
   .tgt_sync             (tgt_sync),
   .tgt_tick_en          (tgt_tick_en),
   .tgt_inject           (tgt_inject),
   .res_done             (res_done),
   .res_status           (res_status),
   .res_latency          (res_latency)
);

// File: tb/test_fi_trial_seq.sv
`timescale 1ns/1ps
module test_fi_trial_seq;

   localparam int RST_W   = 6;
   localparam int DLY_W   = 10;
   localparam int LAT_W   = 8;
   localparam int MIN_RST = 16;
   localparam int LMAX    = (1 << LAT_W) - 1;

   typedef struct {
      bit status;
      int lat;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic             cmd_ready;
   logic [RST_W-1:0] cmd_reset_len = '0;
   logic [DLY_W-1:0] cmd_inject_delay = '0;
   logic             tgt_reset;
   logic             tgt_workload_started = 1'b0;
   logic             tgt_sync;
   logic             tgt_tick_en;
   logic             tgt_inject;
   logic             tgt_error_det = 1'b0;
   logic             res_done;
   logic             res_status;
   logic [LAT_W-1:0] res_latency;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 0;
   bit   done_prev = 0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   fi_trial_seq #(
      .RST_W(RST_W), .DLY_W(DLY_W), .LAT_W(LAT_W), .MIN_RST(MIN_RST)
   ) i_fi_trial_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_reset_len(cmd_reset_len), .cmd_inject_delay(cmd_inject_delay),
      .tgt_reset(tgt_reset), .tgt_workload_started(tgt_workload_started),
      .tgt_sync(tgt_sync), .tgt_tick_en(tgt_tick_en), .tgt_inject(tgt_inject),
      .tgt_error_det(tgt_error_det),
      .res_done(res_done), .res_status(res_status), .res_latency(res_latency)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops one expected result per completed trial
   always @(negedge clk) begin
      if (rst_n && res_done && !done_prev) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R8 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.status) begin
               chk(res_status == 1'b1, "R7 status", int'(res_status), 1);
               chk(int'(res_latency) == e.lat, "R7 latency", int'(res_latency), e.lat);
            end else begin
               chk(res_status == 1'b0, "R6 status", int'(res_status), 0);
               chk(int'(res_latency) == e.lat, "R6 latency", int'(res_latency), e.lat);
            end
            chk(cmd_ready == 1'b1, "R8 idle at done", int'(cmd_ready), 1);
         end
      end
      done_prev = res_done;
   end

   task automatic run_trial(input int rlen, input int dly, input int swait,
                            input int elat, input bit poke, input bit early);
      int   n;
      int   exp_r;
      bit   bad;
      exp_t e;
      exp_r = (rlen < MIN_RST) ? MIN_RST : rlen;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R1 ready in idle", int'(cmd_ready), 1);
      cmd_valid = 1'b1;
      cmd_reset_len = RST_W'(rlen);
      cmd_inject_delay = DLY_W'(dly);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(res_done == 1'b0, "R8 done cleared", int'(res_done), 0);
      n = 0;
      bad = 0;
      while (tgt_reset && n < 200) begin
         if (tgt_tick_en || tgt_sync) bad = 1;
         n++;
         @(negedge clk);
      end
      chk(n == exp_r, "R2 reset length", n, exp_r);
      chk(!bad, "R4 quiet during reset", int'(bad), 0);
      bad = 0;
      for (int i = 0; i < swait; i++) begin
         if (tgt_sync || tgt_tick_en || tgt_reset) bad = 1;
         if (poke && i == 0) begin
            chk(cmd_ready == 1'b0, "R1 busy not ready", int'(cmd_ready), 0);
            cmd_valid = 1'b1;
            cmd_reset_len = RST_W'(40);
            cmd_inject_delay = DLY_W'(3);
         end
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      chk(!bad, "R3 no sync before run", int'(bad), 0);
      if (poke) chk(tgt_reset == 1'b0, "R1 busy command ignored", int'(tgt_reset), 0);
      tgt_workload_started = 1'b1;
      @(negedge clk);
      tgt_workload_started = 1'b0;
      chk(tgt_sync == 1'b1, "R3 sync pulse", int'(tgt_sync), 1);
      chk(tgt_tick_en == 1'b0, "R4 tick off at sync", int'(tgt_tick_en), 0);
      @(negedge clk);
      chk(tgt_sync == 1'b0, "R3 sync one cycle", int'(tgt_sync), 0);
      n = 0;
      bad = 0;
      while (!tgt_inject && n < 2000) begin
         if (!tgt_tick_en) bad = 1;
         n++;
         @(negedge clk);
      end
      chk(n == dly, "R5 injection delay", n, dly);
      chk(!bad && tgt_tick_en, "R4 tick on after sync", int'(tgt_tick_en), 1);
      e.status = (elat == 0);
      e.lat = (elat == 0) ? LMAX : elat;
      sb_q.push_back(e);
      if (early) tgt_error_det = 1'b1;
      @(negedge clk);
      tgt_error_det = 1'b0;
      chk(tgt_inject == 1'b0, "R5 strobe one cycle", int'(tgt_inject), 0);
      if (elat > 0) begin
         repeat (elat - 1) @(negedge clk);
         tgt_error_det = 1'b1;
         @(negedge clk);
         tgt_error_det = 1'b0;
      end
      n = 0;
      while (!res_done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(res_done == 1'b1, "R8 done raised", int'(res_done), 1);
      chk(tgt_tick_en == 1'b0, "R4 tick off at end", int'(tgt_tick_en), 0);
      @(negedge clk);
      chk(res_done == 1'b1, "R8 done held", int'(res_done), 1);
      chk(int'(res_latency) == e.lat, "R8 latency held", int'(res_latency), e.lat);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R9 ready", int'(cmd_ready), 1);
      chk({tgt_reset, tgt_sync, tgt_tick_en, tgt_inject} == 4'b0, "R9 target outputs",
          int'({tgt_reset, tgt_sync, tgt_tick_en, tgt_inject}), 0);
      chk(res_done == 1'b0, "R9 done low", int'(res_done), 0);
      run_trial(20, 5, 3, 10, 1'b0, 1'b0);   // plain detection
      run_trial(3, 0, 0, 1, 1'b0, 1'b0);     // reset floor, zero delay, latency 1
      run_trial(16, 100, 1, LMAX, 1'b0, 1'b0); // detection in the last counting cycle
      run_trial(17, 2, 2, 0, 1'b0, 1'b0);    // no detection: R7 timeout
      run_trial(63, 1, 4, 40, 1'b1, 1'b1);   // busy command poke, error on strobe cycle
      chk(sb_q.size() == 0, "R8 all results seen", sb_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule